// File: doc/BRIEF.md
# Tail-Biting Rate-1/3 Convolutional Encoder

This block applies a rate-1/3 convolutional code with constraint length 7 to a finite block of bits held in an internal buffer. The code is tail-biting. The six memory cells of the shift register are not cleared before encoding. Instead they are preset from the final six bits of the same block, so the encoder ends in the state it started from. No flush bits are appended, and the coded output is exactly three times the block length.

A host first writes the block one bit at a time through a write port. It then pulses a start strobe and presents the block length at the same time. The whole block must already be in the buffer when encoding begins, because the preset state depends on the block's last bits. The encoder then emits one 3-bit code symbol per cycle with a valid flag, and raises a one-cycle completion flag after the last symbol.

Top module: `tbcc_encoder`

## Requirements
- R1: Output `out_bits[k]` is the XOR of the input bit and the register cells selected by generator k. The generators are octal 133, 171 and 165 for k = 0, 1 and 2. The generator's most significant of seven bits weights the current input bit, the next bit weights the newest register cell, and the least significant bit weights the oldest cell.
- R2: When encoding starts with length N, the register is preset so that the newest cell holds buffer bit N-1, the next cell holds bit N-2, and so on, down to the oldest cell holding bit N-6.
- R3: An accepted start produces exactly N valid symbols in N consecutive cycles. The first symbol appears in the cycle after the start edge. Symbol i encodes buffer bit i.
- R4: `done` is high for exactly one cycle, in the cycle directly after the last valid symbol, and `out_valid` is low in that cycle.
- R5: The register state after the last input bit equals the preset state.
- R6: A start whose length is below 6 or above MAX_LEN is ignored and produces no output.
- R7: A start while encoding is in progress is ignored. The running block keeps its length and no extra block follows.
- R8: Buffer writes while encoding is in progress are ignored, both for the running block and for later blocks.
- R9: After reset, `out_valid` and `done` are low.
- R10: A start presented in the cycle in which `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Buffer write enable |
| ld_addr | input | AW = clog2(MAX_LEN) | Buffer bit address |
| ld_bit | input | 1 | Bit to write |
| start | input | 1 | Start pulse; the length is sampled with it |
| blk_len | input | LW = clog2(MAX_LEN+1) | Block length N |
| out_valid | output | 1 | Code symbol valid |
| out_bits | output | 3 | Code symbol, bit k from generator k |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench aims at the wrap-around of the preset. It uses the shortest legal block of 6, where every preset cell comes from the block itself, and the full 128-bit block, where the cells come from the far end of the buffer.

A preset taken in the wrong cell order, or a register that starts from zero, corrupts the first six symbols only. That fault shows up most clearly with a single set bit at the block's end.

The bench also sends lengths just outside the legal range, a start during encoding, buffer writes during encoding and a back-to-back start on the completion cycle. A design that got any of these wrong would emit stray or missing symbols, or symbols computed from altered data.

// File: rtl/tbcc_encoder.sv
module tbcc_encoder #(
  parameter int MAX_LEN = 128,
  parameter int K = 7,
  parameter logic [3*K-1:0] GENS = {7'o165, 7'o171, 7'o133},
  localparam int M = K - 1,
  localparam int AW = $clog2(MAX_LEN),
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_bit,
  input  logic          start,
  input  logic [LW-1:0] blk_len,
  output logic          out_valid,
  output logic [2:0]    out_bits,
  output logic          done
);

  logic [MAX_LEN-1:0] mem;
  logic [M-1:0] sr, init_st, pre;
  logic [LW-1:0] idx, len_q;
  logic busy, cur, len_ok;

  assign len_ok = (blk_len >= LW'(M)) && (blk_len <= LW'(MAX_LEN));
  assign cur = mem[idx[AW-1:0]];
  assign out_valid = busy;

  always_comb begin
    pre = '0;
    for (int j = 1; j <= M; j++) begin
      pre[M-j] = mem[AW'(blk_len - LW'(j))];
    end
  end

  for (genvar k = 0; k < 3; k++) begin : g_out
    assign out_bits[k] = ^({cur, sr} & GENS[k*K +: K]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
      sr <= '0;
      init_st <= '0;
      idx <= '0;
      len_q <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ld_we && !busy) mem[ld_addr] <= ld_bit;
      if (!busy && start && len_ok) begin
        busy <= 1'b1;
        idx <= '0;
        len_q <= blk_len;
        sr <= pre;
        init_st <= pre;
      end else if (busy) begin
        sr <= {cur, sr[M-1:1]};
        idx <= idx + 1'b1;
        if (idx == len_q - 1'b1) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  a_r3_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (idx != len_q - 1'b1) |=> out_valid);
  a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid && $past(out_valid));
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_end_state: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sr == init_st);
  a_r6_bad_len: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !len_ok |=> !out_valid);
  a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(len_q));
  a_r8_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ld_we |=> $stable(mem));

endmodule

// File: tb/tb_tbcc_encoder.sv
`timescale 1ns/1ps
module tb_tbcc_encoder;
  localparam int MAX_LEN = 128;
  localparam int AW = $clog2(MAX_LEN);
  localparam int LW = $clog2(MAX_LEN + 1);

  logic clk = 0, rst_n = 0, ld_we = 0, ld_bit = 0, start = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [LW-1:0] blk_len = '0;
  logic out_valid, done;
  logic [2:0] out_bits;

  tbcc_encoder #(.MAX_LEN(MAX_LEN)) dut (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  bit ref_mem [MAX_LEN];
  logic [2:0] exp_q[$];
  bit prev_valid = 0;
  int done_seen = 0;

  function automatic logic [2:0] ref_sym(int n, int i);
    logic [6:0] g [3];
    logic [2:0] r;
    g[0] = 7'o133; g[1] = 7'o171; g[2] = 7'o165;
    for (int k = 0; k < 3; k++) begin
      r[k] = g[k][6] & ref_mem[i];
      for (int j = 1; j <= 6; j++) r[k] ^= g[k][6-j] & ref_mem[(i - j + n) % n];
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst_n) begin
      if (out_valid) begin
        // R1 R2 R3: each symbol matches the model, in order
        if (exp_q.size() == 0) chk(0, "R3", out_bits, -1);
        else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          chk(out_bits === e, "R1", out_bits, e);
        end
      end
      if (done) begin
        done_seen++;
        // R4: done directly after the last symbol, queue drained
        chk(prev_valid && !out_valid && exp_q.size() == 0, "R4", exp_q.size(), 0);
      end
      prev_valid = out_valid;
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic load_word(int n, int pat);
    for (int i = 0; i < n; i++) begin
      bit b;
      case (pat)
        0: b = 1'b1;
        1: b = (i == n - 1);
        2: b = (i == 0);
        default: b = 1'(($urandom % 2));
      endcase
      ref_mem[i] = b;
      ld_we = 1; ld_addr = AW'(i); ld_bit = b;
      tick();
    end
    ld_we = 0;
  endtask

  task automatic push_exp(int n);
    for (int i = 0; i < n; i++) exp_q.push_back(ref_sym(n, i));
  endtask

  task automatic wait_done();
    int d0;
    d0 = done_seen;
    while (done_seen == d0) tick();
  endtask

  task automatic run(int n);
    start = 1; blk_len = LW'(n); push_exp(n);
    tick();
    start = 0;
    wait_done();
  endtask

  task automatic quiet(int c, string req);
    int v;
    v = 0;
    for (int i = 0; i < c; i++) begin tick(); if (out_valid) v++; end
    chk(v == 0, req, v, 0);
  endtask

  initial begin
    tick(); tick();
    // R9 reset state
    chk(out_valid == 0 && done == 0, "R9", {out_valid, done}, 0);
    rst_n = 1;
    tick();

    // R2 single set bit at the tail drives the preset
    load_word(6, 1);  run(6);
    load_word(12, 1); run(12);
    load_word(9, 2);  run(9);
    load_word(7, 0);  run(7);
    load_word(MAX_LEN, 3); run(MAX_LEN);
    load_word(37, 3); run(37);

    // R6 illegal lengths
    start = 1; blk_len = LW'(5); tick(); start = 0;
    quiet(10, "R6");
    start = 1; blk_len = LW'(MAX_LEN + 1); tick(); start = 0;
    quiet(10, "R6");

    // R7 start during encoding
    load_word(20, 3);
    start = 1; blk_len = LW'(20); push_exp(20); tick();
    start = 0; tick(); tick();
    start = 1; blk_len = LW'(6); tick(); start = 0;
    wait_done();
    quiet(10, "R7");

    // R8 write during encoding, then rerun with unchanged model
    start = 1; blk_len = LW'(20); push_exp(20); tick();
    start = 0; tick();
    ld_we = 1; ld_addr = AW'(15); ld_bit = ~ref_mem[15]; tick();
    ld_addr = AW'(19); ld_bit = ~ref_mem[19]; tick();
    ld_we = 0;
    wait_done();
    run(20); // R8 buffer kept

    // R10 back-to-back start on the done cycle
    load_word(10, 3);
    start = 1; blk_len = LW'(10); push_exp(10); tick(); start = 0;
    wait_done();
    chk(done == 1, "R10", done, 1);
    start = 1; blk_len = LW'(10); push_exp(10); tick(); start = 0;
    wait_done();
    chk(exp_q.size() == 0, "R10", exp_q.size(), 0);
    quiet(5, "R3");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule